// File: doc/BRIEF.md
# Protected Wake-up Source Controller

This block is the always-on wake-up configuration point of a low-power supervisor. A 32-bit configuration word is written over a simple write strobe. The word takes effect only when its top byte carries the unlock key and the global write-lock input is low. A rejected write leaves the stored word untouched and raises a one-cycle error pulse. The stored bits select which of seven pre-synchronised wake-up events may request a wake-up. They also enable the report of battery-voltage events and choose how the RTC output pin is driven.

The wake-up request is registered. It is the OR of all enabled events and is produced only while the system is in backup mode. A two-state tamper tracker controls the RTC pin override. In state TS_ARMED, with the hold mode selected and backup mode active, the pin is forced high. The transition TS_ARMED to TS_TRIPPED is taken on the first clock edge that sees the tamper input high. TS_TRIPPED has no exit except reset, so from then on the pin follows the RTC's own output value.

Top module: `wake_src_ctrl`

## Requirements
- R1: A write with `wr_data[31:24] == 8'hA5` and `wp_lock` low stores the implemented bits of `wr_data`, which are visible on `rd_data` one cycle after the write strobe.
- R2: A write whose key byte is not 8'hA5 leaves `rd_data` unchanged, and `wr_err` is high for exactly the cycle after the strobe.
- R3: A write while `wp_lock` is high is discarded even with the correct key, and `wr_err` pulses as in R2.
- R4: After reset `rd_data` is 0, `wake_req` is 0 and `wr_err` is 0.
- R5: Only bits 0,1,2,4,5,6,8,9,10 are stored. The key field and all other bits read as 0.
- R6: Event `evt_in[i]` is enabled by a fixed register bit: i=0 timer alarm uses bit 0, i=1 RTC alarm bit 1, i=2 battery undervoltage bit 2, i=3 force-wake pin bit 4, i=4 core power-on reset bit 5, i=5 3.3 V undervoltage bit 6, i=6 slow-crystal error bit 10. One cycle after a clock edge, `wake_req` equals `backup_mode` AND the OR of the enabled events, using the register value held before that edge.
- R7: `wake_req` is 0 in the cycle after any edge at which `backup_mode` was low.
- R8: `vbat_report_out` is `vbat_evt_in` AND bit 8, combinationally.
- R9: With bit 9 at 0, `rtc_pin_out` equals `rtc_cfg_in`.
- R10: With bit 9 at 1, `backup_mode` high and no tamper seen since reset, `rtc_pin_out` is 1.
- R11: From the edge after `tamper_in` is first high, `rtc_pin_out` equals `rtc_cfg_in` until reset, whatever `tamper_in` does afterwards.
- R12: `wr_err` is 0 after an accepted write and after cycles with no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write word, key in bits 31:24 |
| wp_lock | input | 1 | Global write lock |
| rd_data | output | 32 | Stored configuration |
| wr_err | output | 1 | One-cycle pulse after a rejected write |
| backup_mode | input | 1 | System is in backup mode |
| evt_in | input | 7 | Synchronised wake-up events, order as in R6 |
| wake_req | output | 1 | Registered wake-up request |
| vbat_evt_in | input | 1 | Battery-voltage event |
| vbat_report_out | output | 1 | Gated battery-event report |
| tamper_in | input | 1 | Tamper detection |
| rtc_cfg_in | input | 1 | Output level configured by the RTC |
| rtc_pin_out | output | 1 | RTC output pin drive |

## Verification
Two pairs of actions can fall in the same cycle. The first is a configuration write and an event: the bench holds all events high while an accepted write enables one source. It then expects `wake_req` to follow the old enables at the first edge and the new ones at the second. The second is tamper arrival and entry into backup mode with the hold mode selected. The bench raises both inputs together and expects the pin high before the edge and equal to `rtc_cfg_in` after it.

// File: rtl/wake_pkg.sv
package wake_pkg;
    localparam int DATA_W       = 32;
    localparam int KEY_W        = 8;
    localparam int NUM_SRC      = 7;
    localparam int VBAT_RPT_BIT = 8;
    localparam int PIN_MODE_BIT = 9;
    localparam logic [KEY_W-1:0] UNLOCK_KEY = 8'hA5;

    // register bit that enables event source i
    function automatic int src_bit(input int i);
        case (i)
            0: return 0;
            1: return 1;
            2: return 2;
            3: return 4;
            4: return 5;
            5: return 6;
            default: return 10;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] impl_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_SRC; i++) m[src_bit(i)] = 1'b1;
        m[VBAT_RPT_BIT] = 1'b1;
        m[PIN_MODE_BIT] = 1'b1;
        return m;
    endfunction

    typedef enum logic {
        TS_ARMED   = 1'b0,
        TS_TRIPPED = 1'b1
    } tamp_state_t;
endpackage

// File: rtl/wake_cfg_reg.sv
module wake_cfg_reg
    import wake_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int KW = KEY_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         wp_lock,
    output logic [W-1:0] cfg_q,
    output logic         wr_err
);
    localparam logic [W-1:0] MASK = W'(impl_mask());

    logic key_ok;
    logic accept;

    assign key_ok = (wr_data[W-1 -: KW] == UNLOCK_KEY);
    assign accept = wr_en && !wp_lock && key_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            wr_err <= 1'b0;
        end else begin
            wr_err <= wr_en && !accept;
            if (accept) cfg_q <= wr_data & MASK;
        end
    end
endmodule

// File: rtl/wake_aggregator.sv
module wake_aggregator #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         backup_mode,
    input  logic [N-1:0] evt_in,
    input  logic [N-1:0] src_en,
    output logic         wake_req
);
    logic any_hit;

    assign any_hit = |(evt_in & src_en);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wake_req <= 1'b0;
        else        wake_req <= backup_mode && any_hit;
    end
endmodule

// File: rtl/tamper_override.sv
module tamper_override
    import wake_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tamper_in,
    input  logic backup_mode,
    input  logic hold_mode,
    input  logic rtc_cfg_in,
    output logic rtc_pin_out
);
    tamp_state_t state_q;
    tamp_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TS_ARMED:   if (tamper_in) state_d = TS_TRIPPED;
            TS_TRIPPED: state_d = TS_TRIPPED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TS_ARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        rtc_pin_out = rtc_cfg_in;
        unique case (state_q)
            TS_ARMED:   if (hold_mode && backup_mode) rtc_pin_out = 1'b1;
            TS_TRIPPED: rtc_pin_out = rtc_cfg_in;
        endcase
    end
endmodule

// File: rtl/wake_src_ctrl.sv
module wake_src_ctrl
    import wake_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wp_lock,
    output logic [DATA_W-1:0] rd_data,
    output logic              wr_err,
    input  logic              backup_mode,
    input  logic [NUM_SRC-1:0] evt_in,
    output logic              wake_req,
    input  logic              vbat_evt_in,
    output logic              vbat_report_out,
    input  logic              tamper_in,
    input  logic              rtc_cfg_in,
    output logic              rtc_pin_out
);
    logic [DATA_W-1:0]  cfg_q;
    logic [NUM_SRC-1:0] src_en;

    wake_cfg_reg #(.W(DATA_W), .KW(KEY_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .wp_lock (wp_lock),
        .cfg_q   (cfg_q),
        .wr_err  (wr_err)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_en
        assign src_en[g] = cfg_q[src_bit(g)];
    end

    wake_aggregator #(.N(NUM_SRC)) u_agg (
        .clk         (clk),
        .rst_n       (rst_n),
        .backup_mode (backup_mode),
        .evt_in      (evt_in),
        .src_en      (src_en),
        .wake_req    (wake_req)
    );

    tamper_override u_tamp (
        .clk         (clk),
        .rst_n       (rst_n),
        .tamper_in   (tamper_in),
        .backup_mode (backup_mode),
        .hold_mode   (cfg_q[PIN_MODE_BIT]),
        .rtc_cfg_in  (rtc_cfg_in),
        .rtc_pin_out (rtc_pin_out)
    );

    assign vbat_report_out = vbat_evt_in && cfg_q[VBAT_RPT_BIT];
    assign rd_data         = cfg_q;
endmodule

// File: rtl/wake_src_ctrl_chk.sv
module wake_src_ctrl_chk
    import wake_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              wp_lock,
    input logic [DATA_W-1:0] rd_data,
    input logic              wr_err,
    input logic              backup_mode,
    input logic              wake_req,
    input logic              vbat_report_out,
    input logic              tamper_in,
    input logic              rtc_cfg_in,
    input logic              rtc_pin_out
);
    localparam logic [DATA_W-1:0] MASK = impl_mask();

    logic key_ok;
    assign key_ok = (wr_data[DATA_W-1 -: KEY_W] == UNLOCK_KEY);

    assert_accept_store_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wp_lock && key_ok) |=> (rd_data == ($past(wr_data) & MASK)) && !wr_err);

    assert_bad_key_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !key_ok) |=> $stable(rd_data) && wr_err);

    assert_locked_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wp_lock) |=> $stable(rd_data) && wr_err);

    assert_no_err_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> !wr_err);

    assert_no_wake_awake_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !backup_mode |=> !wake_req);

    assert_vbat_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[VBAT_RPT_BIT] |-> !vbat_report_out);

    assert_pin_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[PIN_MODE_BIT] |-> (rtc_pin_out == rtc_cfg_in));

    assert_tamper_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tamper_in |=> (rtc_pin_out == rtc_cfg_in));
endmodule

bind wake_src_ctrl wake_src_ctrl_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .wr_en           (wr_en),
    .wr_data         (wr_data),
    .wp_lock         (wp_lock),
    .rd_data         (rd_data),
    .wr_err          (wr_err),
    .backup_mode     (backup_mode),
    .wake_req        (wake_req),
    .vbat_report_out (vbat_report_out),
    .tamper_in       (tamper_in),
    .rtc_cfg_in      (rtc_cfg_in),
    .rtc_pin_out     (rtc_pin_out)
);

// File: tb/tb_wake_src_ctrl.sv
module tb_wake_src_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        wp_lock = 1'b0;
    logic [31:0] rd_data;
    logic        wr_err;
    logic        backup_mode = 1'b0;
    logic [6:0]  evt_in = '0;
    logic        wake_req;
    logic        vbat_evt_in = 1'b0;
    logic        vbat_report_out;
    logic        tamper_in = 1'b0;
    logic        rtc_cfg_in = 1'b0;
    logic        rtc_pin_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wake_src_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wp_lock(wp_lock), .rd_data(rd_data), .wr_err(wr_err),
        .backup_mode(backup_mode), .evt_in(evt_in), .wake_req(wake_req),
        .vbat_evt_in(vbat_evt_in), .vbat_report_out(vbat_report_out),
        .tamper_in(tamper_in), .rtc_cfg_in(rtc_cfg_in), .rtc_pin_out(rtc_pin_out)
    );

    localparam logic [31:0] IMPL = 32'h0000_0777;

    function automatic int pos(input int i);
        int t[7] = '{0, 1, 2, 4, 5, 6, 10};
        return t[i];
    endfunction

    function automatic logic [31:0] build(input logic [6:0] m);
        logic [31:0] d = '0;
        for (int i = 0; i < 7; i++) if (m[i]) d[pos(i)] = 1'b1;
        return d;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_write(input logic [31:0] d);
        wr_en = 1'b1;
        wr_data = d;
        tick();
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        tick();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        #3;
        do_reset();
        // R4 reset state
        chk("R4 rd_data", rd_data, 32'h0);
        chk("R4 wake_req", {31'b0, wake_req}, 32'h0);
        chk("R4 wr_err", {31'b0, wr_err}, 32'h0);

        // R1/R5 full-word readback and R12 no error on accept
        do_write(32'hA5FF_FFFF);
        chk("R5 implemented bits only", rd_data, IMPL);
        chk("R12 no err after accept", {31'b0, wr_err}, 32'h0);
        tick();
        chk("R12 no err idle", {31'b0, wr_err}, 32'h0);
        do_write(32'hA500_0000);
        chk("R1 clear", rd_data, 32'h0);

        // R2 every wrong key
        do_write(32'hA500_0421);
        held = rd_data;
        chk("R1 store", held, 32'h0000_0421);
        for (int k = 0; k < 256; k++) begin
            if (k != 8'hA5) begin
                do_write({k[7:0], 24'h00_0356});
                chk("R2 bad key data", rd_data, held);
                chk("R2 bad key err", {31'b0, wr_err}, 32'h1);
                tick();
                chk("R2 err one cycle", {31'b0, wr_err}, 32'h0);
            end
        end

        // R3 lock
        wp_lock = 1'b1;
        do_write(32'hA500_0777);
        chk("R3 locked data", rd_data, held);
        chk("R3 locked err", {31'b0, wr_err}, 32'h1);
        wp_lock = 1'b0;
        tick();
        chk("R3 err one cycle", {31'b0, wr_err}, 32'h0);

        // R6 / R7 exhaustive mask x event sweep
        for (int m = 0; m < 128; m++) begin
            do_write(32'hA500_0000 | build(m[6:0]));
            chk("R6 mask stored", rd_data, build(m[6:0]));
            backup_mode = 1'b1;
            for (int e = 0; e < 128; e++) begin
                evt_in = e[6:0];
                tick();
                chk("R6 wake", {31'b0, wake_req}, {31'b0, |(e[6:0] & m[6:0])});
            end
            backup_mode = 1'b0;
            evt_in = 7'h7F;
            tick();
            chk("R7 not backup", {31'b0, wake_req}, 32'h0);
            evt_in = '0;
        end

        // R6 write and event in the same cycle
        do_write(32'hA500_0000);
        backup_mode = 1'b1;
        evt_in = 7'h7F;
        do_write(32'hA500_0002);
        chk("R6 old enables at first edge", {31'b0, wake_req}, 32'h0);
        tick();
        chk("R6 new enables at second edge", {31'b0, wake_req}, 32'h1);
        evt_in = '0;
        backup_mode = 1'b0;
        tick();

        // R8 battery report
        for (int b = 0; b < 4; b++) begin
            do_write(b[1] ? 32'hA500_0100 : 32'hA500_0000);
            vbat_evt_in = b[0];
            #1;
            chk("R8 vbat report", {31'b0, vbat_report_out}, {31'b0, b[0] & b[1]});
        end
        vbat_evt_in = 1'b0;

        // R9 / R10 pin modes, no tamper
        do_reset();
        for (int p = 0; p < 8; p++) begin
            do_write(p[2] ? 32'hA500_0200 : 32'hA500_0000);
            backup_mode = p[1];
            rtc_cfg_in = p[0];
            #1;
            if (p[2] && p[1])
                chk("R10 hold high", {31'b0, rtc_pin_out}, 32'h1);
            else
                chk("R9 follow cfg", {31'b0, rtc_pin_out}, {31'b0, p[0]});
        end

        // R11 tamper with backup entry in the same cycle
        do_write(32'hA500_0200);
        backup_mode = 1'b0;
        tick();
        rtc_cfg_in = 1'b0;
        backup_mode = 1'b1;
        tamper_in = 1'b1;
        #1;
        chk("R10 before tamper edge", {31'b0, rtc_pin_out}, 32'h1);
        tick();
        tamper_in = 1'b0;
        #1;
        chk("R11 released", {31'b0, rtc_pin_out}, 32'h0);
        for (int c = 0; c < 4; c++) begin
            rtc_cfg_in = c[0];
            tick();
            chk("R11 stays released", {31'b0, rtc_pin_out}, {31'b0, c[0]});
        end
        do_reset();
        rtc_cfg_in = 1'b0;
        do_write(32'hA500_0200);
        #1;
        chk("R11 reset rearms", {31'b0, rtc_pin_out}, 32'h1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule